// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

After a start pulse this block drives the full DDR2 power-up command sequence onto a DRAM command/address bus. It first holds the bus in NOP for a power-up pause. It then issues a precharge-all, loads the extended mode register with the DLL enabled and the on-die termination chosen, loads the mode register with DLL reset, and precharges all banks again. Next come a run of auto-refresh commands. The operating mode word follows, then a pair of extended mode loads that enter and leave off-chip-driver calibration default. When the mode-register settle time has passed, the block reports done.

The termination value follows from the number of DIMMs on the channel: one DIMM selects 150 Ω and two select 75 Ω. Any other count is a configuration fault. In that case the three extended-mode loads are left out and a fault flag is raised. CAS latency, burst length, write recovery and DIMM count are captured at the start pulse. The wait lengths are parameters. The power-up pause and the gap between refreshes are derived from a clock-frequency parameter and a time in microseconds. Precharge, refresh and mode-register waits are given directly in cycles.

Top module: `ddr2i_seq`

## Requirements
- R1: Out of reset, and whenever idle, the bus shows NOP with bank and row address zero, and `done_o` and `cfg_err_o` are low.
- R2: The start pulse is followed by exactly PWRUP_US*CLK_MHZ NOP cycles. Then comes a precharge-all: {cs_n,ras_n,cas_n,we_n}=0010, row bit 10 set, bank 0. It is followed by TRP_CYC NOP cycles.
- R3: For DIMM count 1 or 2, the next command is a mode load ({cs_n,ras_n,cas_n,we_n}=0000) to bank 1 with row bit 0 clear (DLL on) and bits 9:7 zero. For one DIMM, bit 6 is 1 and bit 2 is 0. For two DIMMs, bit 6 is 0 and bit 2 is 1. TMRD_CYC NOP cycles follow.
- R4: Next is a mode load to bank 0 with only row bit 8 set (DLL reset), then TMRD_CYC NOP cycles. A second precharge-all with TRP_CYC NOP cycles follows.
- R5: REF_N auto-refresh commands ({cs_n,ras_n,cas_n,we_n}=0001, address 0) follow. Each one is trailed by max(TRFC_CYC, REFGAP_US*CLK_MHZ) NOP cycles.
- R6: The operating mode load goes to bank 0. Bits 2:0 hold 010 for burst 4 or 011 for burst 8. Bit 3 is 1 (interleaved). Bits 6:4 hold the CAS latency (2 to 6). Bits 11:9 hold write recovery minus one. All other bits are 0.
- R7: For a valid DIMM count, two bank-1 mode loads follow, each trailed by TMRD_CYC NOP cycles. The first has bits 9:7 = 111 and the second has bits 9:7 = 000. Both carry the same termination bits as R3.
- R8: Every command lasts one cycle. Between commands the bus is NOP ({cs_n,ras_n,cas_n,we_n}=0111) with zero address and bank.
- R9: `done_o` first reads high TMRD_CYC+5 cycles after the cycle of the final mode load. It stays high until the next start pulse, which clears it at the same edge.
- R10: For a DIMM count other than 1 or 2, the three bank-1 mode loads are skipped and `cfg_err_o` reads high. The operating mode load is then trailed by TMRD_CYC+3 NOP cycles.
- R11: A start pulse during a running sequence is ignored. Configuration inputs are sampled only at an accepted start, so changes while running have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted when idle or done |
| cas_lat_i | input | 3 | CAS latency in cycles, 2 to 6 |
| burst8_i | input | 1 | 1 selects burst 8, 0 selects burst 4 |
| wr_rec_i | input | 3 | Write recovery in cycles, 2 to 6 |
| dimm_cnt_i | input | 2 | DIMMs on the channel; 1 or 2 valid |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BANK_W | Bank address |
| addr_o | output | ROW_W | Row address |
| done_o | output | 1 | Sequence complete |
| cfg_err_o | output | 1 | Invalid DIMM count captured at start |

## Verification
The hardest situation to reach is a second start pulse, together with changed configuration inputs, arriving deep inside the refresh phase. This must leave the remaining schedule untouched. The bench injects both at a fixed offset during a run and then compares the whole recorded command log, including cycle times, against a schedule computed from the captured settings. The faulty-count path is driven with a count of three. The log must then lack every bank-1 load while still showing the longer settle before done.

// File: rtl/ddr2i_pkg.sv
package ddr2i_pkg;

    localparam int MODE_W = 16;

    // Command encoding {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR  = 4'b0000,
        CMD_REF  = 4'b0001,
        CMD_PREA = 4'b0010,
        CMD_NOP  = 4'b0111
    } dram_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PWRUP, ST_PREA1, ST_EMRS_DLL, ST_MRS_RST, ST_PREA2,
        ST_REF, ST_MRS_OP, ST_OCD_DEF, ST_OCD_EXIT, ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [2:0] cas_lat;
        logic       burst8;
        logic [2:0] wr_rec;
        logic [1:0] odt_sel;   // 01: 150 ohm, 10: 75 ohm, 00: invalid
        logic       bad_cnt;
    } init_cfg_t;

    function automatic init_cfg_t make_cfg(logic [2:0] cl, logic b8,
                                           logic [2:0] wr, logic [1:0] dimms);
        init_cfg_t c;
        c.cas_lat = cl;
        c.burst8  = b8;
        c.wr_rec  = wr;
        c.odt_sel = (dimms == 2'd1) ? 2'b01 : (dimms == 2'd2) ? 2'b10 : 2'b00;
        c.bad_cnt = (dimms != 2'd1) && (dimms != 2'd2);
        return c;
    endfunction

    function automatic logic [MODE_W-1:0] mrs_word(init_cfg_t c);
        logic [MODE_W-1:0] w;
        w        = '0;
        w[2:0]   = c.burst8 ? 3'd3 : 3'd2;
        w[3]     = 1'b1;
        w[6:4]   = c.cas_lat;
        w[11:9]  = c.wr_rec - 3'd1;
        return w;
    endfunction

    function automatic logic [MODE_W-1:0] emrs_word(init_cfg_t c, logic ocd_dflt);
        logic [MODE_W-1:0] w;
        w       = '0;
        w[6]    = c.odt_sel[0];
        w[2]    = c.odt_sel[1];
        w[9:7]  = ocd_dflt ? 3'b111 : 3'b000;
        return w;
    endfunction

endpackage

// File: rtl/ddr2i_step_timer.sv
module ddr2i_step_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    assign last = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (!last)
            cnt <= cnt + 1'b1;
    end

    // R2
    timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit);
endmodule

// File: rtl/ddr2i_cmd_encoder.sv
module ddr2i_cmd_encoder
    import ddr2i_pkg::*;
#(
    parameter int ROW_W  = 14,
    parameter int BANK_W = 3
) (
    input  seq_state_e         state,
    input  logic               issue,
    input  init_cfg_t          cfg,
    output dram_cmd_e          cmd,
    output logic [BANK_W-1:0]  ba,
    output logic [ROW_W-1:0]   addr
);
    logic [MODE_W-1:0] word;

    always_comb begin
        cmd  = CMD_NOP;
        ba   = '0;
        word = '0;
        if (issue) begin
            case (state)
                ST_PREA1, ST_PREA2: begin cmd = CMD_PREA; word[10] = 1'b1; end
                ST_EMRS_DLL: begin cmd = CMD_LMR; ba = BANK_W'(1); word = emrs_word(cfg, 1'b0); end
                ST_MRS_RST:  begin cmd = CMD_LMR; word[8] = 1'b1; end
                ST_REF:      cmd = CMD_REF;
                ST_MRS_OP:   begin cmd = CMD_LMR; word = mrs_word(cfg); end
                ST_OCD_DEF:  begin cmd = CMD_LMR; ba = BANK_W'(1); word = emrs_word(cfg, 1'b1); end
                ST_OCD_EXIT: begin cmd = CMD_LMR; ba = BANK_W'(1); word = emrs_word(cfg, 1'b0); end
                default: ;
            endcase
        end
    end

    assign addr = ROW_W'(word);
endmodule

// File: rtl/ddr2i_seq.sv
module ddr2i_seq
    import ddr2i_pkg::*;
#(
    parameter int CLK_MHZ   = 250,
    parameter int PWRUP_US  = 200,
    parameter int REFGAP_US = 100,
    parameter int TRP_CYC   = 4,
    parameter int TRFC_CYC  = 32,
    parameter int TMRD_CYC  = 2,
    parameter int REF_N     = 8,
    parameter int ROW_W     = 14,
    parameter int BANK_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [2:0]        cas_lat_i,
    input  logic              burst8_i,
    input  logic [2:0]        wr_rec_i,
    input  logic [1:0]        dimm_cnt_i,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [BANK_W-1:0] ba_o,
    output logic [ROW_W-1:0]  addr_o,
    output logic              done_o,
    output logic              cfg_err_o
);
    localparam int PWR_CYC  = PWRUP_US * CLK_MHZ;
    localparam int GAP_CYC  = REFGAP_US * CLK_MHZ;
    localparam int REF_WAIT = (TRFC_CYC > GAP_CYC) ? TRFC_CYC : GAP_CYC;
    localparam int SETTLE   = TMRD_CYC + 3;
    localparam int MAX_A    = (PWR_CYC > REF_WAIT) ? PWR_CYC : REF_WAIT;
    localparam int MAX_B    = (SETTLE > TRP_CYC) ? SETTLE : TRP_CYC;
    localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam int REF_CW   = (REF_N > 1) ? $clog2(REF_N) : 1;

    seq_state_e        state, state_n;
    init_cfg_t         cfg_q;
    logic [REF_CW-1:0] ref_idx;
    logic [CNT_W-1:0]  limit, t_cnt;
    logic              t_last, clr, ref_again, busy;
    dram_cmd_e         cmd;

    assign busy = (state != ST_IDLE) && (state != ST_DONE);

    always_comb begin
        case (state)
            ST_PWRUP:                         limit = CNT_W'(PWR_CYC - 1);
            ST_PREA1, ST_PREA2:               limit = CNT_W'(TRP_CYC);
            ST_EMRS_DLL, ST_MRS_RST, ST_OCD_DEF: limit = CNT_W'(TMRD_CYC);
            ST_REF:                           limit = CNT_W'(REF_WAIT);
            ST_MRS_OP:   limit = cfg_q.bad_cnt ? CNT_W'(SETTLE) : CNT_W'(TMRD_CYC);
            ST_OCD_EXIT:                      limit = CNT_W'(SETTLE);
            default:                          limit = '0;
        endcase
    end

    always_comb begin
        state_n   = state;
        ref_again = 1'b0;
        if (!busy) begin
            if (start_i) state_n = ST_PWRUP;
        end else if (t_last) begin
            case (state)
                ST_PWRUP:    state_n = ST_PREA1;
                ST_PREA1:    state_n = cfg_q.bad_cnt ? ST_MRS_RST : ST_EMRS_DLL;
                ST_EMRS_DLL: state_n = ST_MRS_RST;
                ST_MRS_RST:  state_n = ST_PREA2;
                ST_PREA2:    state_n = ST_REF;
                ST_REF: begin
                    if (ref_idx == REF_CW'(REF_N - 1)) state_n = ST_MRS_OP;
                    else ref_again = 1'b1;
                end
                ST_MRS_OP:   state_n = cfg_q.bad_cnt ? ST_DONE : ST_OCD_DEF;
                ST_OCD_DEF:  state_n = ST_OCD_EXIT;
                ST_OCD_EXIT: state_n = ST_DONE;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    assign clr = (state_n != state) || ref_again;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cfg_q   <= '0;
            ref_idx <= '0;
            done_o  <= 1'b0;
        end else begin
            state  <= state_n;
            done_o <= (state == ST_DONE) && !start_i;
            if (!busy && start_i)
                cfg_q <= make_cfg(cas_lat_i, burst8_i, wr_rec_i, dimm_cnt_i);
            if (state != ST_REF) ref_idx <= '0;
            else if (ref_again)  ref_idx <= ref_idx + 1'b1;
        end
    end

    ddr2i_step_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .clr(clr), .limit(limit), .cnt(t_cnt), .last(t_last)
    );

    ddr2i_cmd_encoder #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_enc (
        .state(state), .issue(t_cnt == '0), .cfg(cfg_q),
        .cmd(cmd), .ba(ba_o), .addr(addr_o)
    );

    assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
    assign cfg_err_o = cfg_q.bad_cnt;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (cmd == CMD_NOP && !done_o));
    // R8
    cmd_single_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NOP) |=> (cmd == CMD_NOP));
    // R10
    odt_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LMR && ba_o == BANK_W'(1)) |-> !cfg_err_o);
    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o);
    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_q));
    // R5
    ref_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ref_idx <= REF_CW'(REF_N - 1));
endmodule

// File: tb/tb_ddr2i_seq.sv
`timescale 1ns/1ps
module tb_ddr2i_seq;
    localparam int CLK_MHZ = 1, PWRUP_US = 200, REFGAP_US = 100;
    localparam int TRP = 3, TRFC = 20, TMRD = 2, REF_N = 8;
    localparam int ROW_W = 14, BANK_W = 3;
    localparam int PWR = PWRUP_US * CLK_MHZ;
    localparam int GAP = REFGAP_US * CLK_MHZ;
    localparam int REFW = (TRFC > GAP) ? TRFC : GAP;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, b8 = 1'b0;
    logic [2:0] cl = 3'd4, wr = 3'd4;
    logic [1:0] dimms = 2'd1;
    logic cs_n, ras_n, cas_n, we_n, done, err;
    logic [BANK_W-1:0] ba;
    logic [ROW_W-1:0] addr;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    ddr2i_seq #(.CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .REFGAP_US(REFGAP_US),
        .TRP_CYC(TRP), .TRFC_CYC(TRFC), .TMRD_CYC(TMRD), .REF_N(REF_N),
        .ROW_W(ROW_W), .BANK_W(BANK_W)) dut (
        .clk(clk), .rst(rst), .start_i(start), .cas_lat_i(cl), .burst8_i(b8),
        .wr_rec_i(wr), .dimm_cnt_i(dimms), .cs_n_o(cs_n), .ras_n_o(ras_n),
        .cas_n_o(cas_n), .we_n_o(we_n), .ba_o(ba), .addr_o(addr),
        .done_o(done), .cfg_err_o(err));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Expected schedule
    int e_n, e_t[0:31], e_cmd[0:31], e_ba[0:31], e_addr[0:31], e_done;
    string e_tag[0:31];

    task automatic push(input int t, input int c, input int b, input int a, input string tg);
        e_t[e_n] = t; e_cmd[e_n] = c; e_ba[e_n] = b; e_addr[e_n] = a; e_tag[e_n] = tg;
        e_n++;
    endtask

    task automatic build(input int d, input int cas, input int bur8, input int wrr);
        int t, odt, op, lastlmr;
        bit good;
        good = (d == 1) || (d == 2);
        odt  = (d == 1) ? (1 << 6) : (d == 2) ? (1 << 2) : 0;
        op   = (bur8 ? 3 : 2) | (1 << 3) | (cas << 4) | ((wrr - 1) << 9);
        e_n = 0;
        t = PWR;
        push(t, 4'b0010, 0, 1 << 10, "R2"); t += 1 + TRP;
        if (good) begin push(t, 4'b0000, 1, odt, "R3"); t += 1 + TMRD; end
        push(t, 4'b0000, 0, 1 << 8, "R4"); t += 1 + TMRD;
        push(t, 4'b0010, 0, 1 << 10, "R4"); t += 1 + TRP;
        for (int k = 0; k < REF_N; k++) begin push(t, 4'b0001, 0, 0, "R5"); t += 1 + REFW; end
        push(t, 4'b0000, 0, op, "R6"); lastlmr = t; t += 1 + TMRD;
        if (good) begin
            push(t, 4'b0000, 1, odt | (7 << 7), "R7"); t += 1 + TMRD;
            lastlmr = t;
            push(t, 4'b0000, 1, odt, "R7");
        end
        e_done = lastlmr + TMRD + 5;
    endtask

    // Runs one sequence; inject >= 0 adds a start pulse and config change while busy
    task automatic run_case(input int d, input int cas, input int bur8, input int wrr,
                            input int inject);
        int g_n, g_t[0:31], g_cmd[0:31], g_ba[0:31], g_addr[0:31], g_done, nop_bad;
        build(d, cas, bur8, wrr);
        @(negedge clk);
        dimms = 2'(d); cl = 3'(cas); b8 = bur8[0]; wr = 3'(wrr); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        g_n = 0; g_done = -1; nop_bad = 0;
        chk(done == 1'b0, "R9 done cleared by start", int'(done), 0);
        for (int o = 0; o < 3000 && g_done < 0; o++) begin
            if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
                if (g_n < 32) begin
                    g_t[g_n] = o; g_cmd[g_n] = int'({cs_n, ras_n, cas_n, we_n});
                    g_ba[g_n] = int'(ba); g_addr[g_n] = int'(addr);
                end
                g_n++;
            end else if (addr != '0 || ba != '0) nop_bad++;
            if (done) g_done = o;
            if (o == inject) begin
                start = 1'b1; dimms = 2'd3 - dimms; cl = 3'd6; b8 = ~b8; wr = 3'd2;
            end
            if (o == inject + 1) start = 1'b0;
            @(negedge clk);
        end
        chk(g_n == e_n, (inject >= 0) ? "R11 command count" : "R8 command count", g_n, e_n);
        for (int i = 0; i < e_n && i < g_n; i++) begin
            chk(g_t[i] == e_t[i], {e_tag[i], " cycle"}, g_t[i], e_t[i]);
            chk(g_cmd[i] == e_cmd[i] && g_ba[i] == e_ba[i] && g_addr[i] == e_addr[i],
                {e_tag[i], " cmd/ba/addr"}, (g_cmd[i] << 20) | (g_ba[i] << 16) | g_addr[i],
                (e_cmd[i] << 20) | (e_ba[i] << 16) | e_addr[i]);
        end
        chk(nop_bad == 0, "R8 NOP address zero", nop_bad, 0);
        chk(g_done == e_done, "R9 done timing", g_done, e_done);
        chk(err == ((d != 1 && d != 2) ? 1'b1 : 1'b0), "R10 error flag", int'(err),
            (d != 1 && d != 2) ? 1 : 0);
        for (int w = 0; w < 25; w++) @(negedge clk);
        chk(done == 1'b1, "R9 done holds", int'(done), 1);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111 && addr == '0 && ba == '0, "R1 idle bus",
            int'({cs_n, ras_n, cas_n, we_n}), 7);
        chk(done == 1'b0 && err == 1'b0, "R1 flags low", int'({done, err}), 0);
    endtask

    task automatic t_one_dimm;   run_case(1, 4, 0, 4, -1); endtask
    task automatic t_two_dimm;   run_case(2, 6, 1, 6, -1); endtask
    task automatic t_min_vals;   run_case(1, 2, 1, 2, -1); endtask
    task automatic t_bad_count;  run_case(3, 5, 0, 3, -1); endtask  // R10
    task automatic t_busy_start; run_case(2, 3, 0, 5, 500); endtask // R11
    task automatic t_zero_count; run_case(0, 4, 1, 4, -1); endtask  // R10

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_one_dimm();
        t_two_dimm();
        t_min_vals();
        t_bad_count();
        t_busy_start();
        t_zero_count();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule